// File: doc/BRIEF.md
# UART Bus Register Front End

This block is the register face of a serial port. It is a 32-bit Wishbone slave with four word registers: a line setup word, a combined FIFO status word, a receive data word and a transmit data word. Behind it sit two synchronous FIFOs, one for received characters and one for characters waiting to go out. Each FIFO has a depth of 2^LG. The serial receiver and transmitter engines are outside the block. They connect through simple strobe ports.

Received characters are queued together with their per-character break, framing and parity flags. A bus read of the receive word pops one entry. Bus writes to the transmit word queue characters, start a break, or end a break. The transmitter engine takes characters whenever it is not busy and flow control allows. Four level interrupts and a clear-to-send output are derived from FIFO occupancy.

Top module: `uart_bus_frontend`

## Requirements
- R1: Every access is a full 32-bit word at word address 0 (setup), 1 (FIFO status), 2 (receive data) or 3 (transmit data). `ack_o` is high for exactly one cycle. It rises on the second rising edge after `cyc_i`/`stb_i` are first sampled high. Read data is valid while `ack_o` is high.
- R2: The setup register holds 31 bits and resets to INIT_SETUP. Bit 31 reads 0. `setup_o` mirrors the stored value. Setup bit 30 set turns off transmit flow control.
- R3: The FIFO status word has the receive half in bits [31:16] and the transmit half in bits [15:0]. Each half is {LG[3:0], fill[9:0], H, Z}. The receive fill is the count of valid entries, H is fill >= depth/2, and Z is fill != 0. The transmit fill is the count of free slots, H is free >= depth/2, and Z is free != 0. Writes to this word change nothing.
- R4: Reading the receive word returns the oldest character in [7:0], its break flag in bit 9, its framing flag in bit 10 and its parity flag in bit 11. The read pops that entry, so the flags belong only to that character.
- R5: Reading the receive word while the receive FIFO is empty returns bit 8 set and pops nothing.
- R6: A character strobed in while the receive FIFO is full is dropped and sets the sticky overflow bit 12 of the receive word. `cts_o` is low exactly while the receive FIFO has no free slot.
- R7: Writing the receive word with bit 12 set empties the receive FIFO and clears the overflow bit. It also pulses `rx_reset_o` for one cycle so the receiver waits for an idle line.
- R8: A transmit-word write with bits 9 and 11 clear queues bits [7:0] when no break is active. Queued characters are offered on `tx_valid_o`/`tx_byte_o` in order. One is taken on each cycle in which `tx_valid_o` is high and `tx_busy_i` is low. With setup bit 30 clear, nothing is offered while `rts_i` is low.
- R9: A transmit-word write with bit 9 set (bit 11 clear) starts a break (`tx_break_o` high) and queues nothing. During a break no character is offered. A write with bits 9 and 11 clear during a break ends the break and queues nothing.
- R10: Reading the transmit word returns bit 8 busy (FIFO not empty or `tx_busy_i`), bit 9 break, bit 10 `tx_line_i`, bit 11 overflow, bit 12 FIFO not full, bit 13 FIFO count >= depth/2 and bit 14 `rts_i`.
- R11: A character written while the transmit FIFO is full is dropped and sets the overflow bit. A write with bit 11 set empties the transmit FIFO and clears the overflow bit.
- R12: `rx_int_o` = receive FIFO not empty. `tx_int_o` = transmit FIFO not full. `rxfifo_int_o` = receive count >= depth/2. `txfifo_int_o` = transmit free slots >= depth/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access acknowledge |
| rdata_o | output | 32 | Read data |
| setup_o | output | 31 | Line setup to the serial engines |
| rx_valid_i | input | 1 | Receiver character strobe |
| rx_byte_i | input | 8 | Received character |
| rx_brk_i | input | 1 | Break seen with this character |
| rx_frame_err_i | input | 1 | Framing error with this character |
| rx_par_err_i | input | 1 | Parity error with this character |
| rx_reset_o | output | 1 | Receiver restart pulse |
| cts_o | output | 1 | Clear to send |
| tx_valid_o | output | 1 | Character offered to transmitter |
| tx_byte_o | output | 8 | Offered character |
| tx_busy_i | input | 1 | Transmitter busy |
| tx_line_i | input | 1 | Current transmit line level |
| tx_break_o | output | 1 | Hold line in break |
| rts_i | input | 1 | Far end ready to receive |
| rx_int_o | output | 1 | Receive character available |
| tx_int_o | output | 1 | Transmit slot available |
| rxfifo_int_o | output | 1 | Receive FIFO at least half full |
| txfifo_int_o | output | 1 | Transmit FIFO at least half empty |

## Verification
The assertions assume that the master holds `cyc_i`/`stb_i` steady until it sees `ack_o` and drops them in the following cycle. They also assume that `tx_busy_i` only rises in reaction to a character taken from `tx_valid_o`. The stimulus drives each bus access through one task that follows this handshake. A small engine model in the bench raises busy for a few cycles after each accepted character. Receive strobes are single-cycle pulses, and none is issued while a bus access is in flight.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  typedef enum logic [1:0] {
    REG_SETUP = 2'd0,
    REG_FSTAT = 2'd1,
    REG_RXDAT = 2'd2,
    REG_TXDAT = 2'd3
  } reg_addr_e;

  localparam int SETUP_W      = 31;
  localparam int SETUP_NOFLOW = 30;
  // receive word
  localparam int RX_EMPTY_B = 8;
  localparam int RX_BRK_B   = 9;
  localparam int RX_FRM_B   = 10;
  localparam int RX_PAR_B   = 11;
  localparam int RX_ERR_B   = 12;
  // transmit word
  localparam int TX_BUSY_B  = 8;
  localparam int TX_BRK_B   = 9;
  localparam int TX_LINE_B  = 10;
  localparam int TX_ERR_B   = 11;
  localparam int TX_NFULL_B = 12;
  localparam int TX_HALF_B  = 13;
  localparam int TX_RTS_B   = 14;
  localparam int FILL_W     = 10;
endpackage

// File: rtl/fe_fifo.sv
module fe_fifo #(
  parameter int W  = 8,
  parameter int LG = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  data_o,
  output logic [LG:0]   count_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int DEPTH = 1 << LG;

  logic [W-1:0]  mem_q [DEPTH];
  logic [LG-1:0] wr_q, rd_q;
  logic [LG:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (LG+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + (LG+1)'(do_push) - (LG+1)'(do_pop);
    end
  end

  // R6
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= (LG+1)'(DEPTH));
  // R8
  count_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o && !clr_i) |=> (count_o == $past(count_o) + 1'b1));
  // R7
  clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/fe_bus_stage.sv
module fe_bus_stage (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cyc_i,
  input  logic        stb_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic        act_o,
  output logic        act_we_o,
  output logic [1:0]  act_addr_o,
  output logic [31:0] act_wdata_o,
  output logic        ack_o
);
  logic req;

  // one access in flight; a held strobe during ack is not a new request
  assign req = cyc_i && stb_i && !act_o && !ack_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o       <= 1'b0;
      act_we_o    <= 1'b0;
      act_addr_o  <= '0;
      act_wdata_o <= '0;
      ack_o       <= 1'b0;
    end else begin
      act_o <= req;
      ack_o <= act_o;
      if (req) begin
        act_we_o    <= we_i;
        act_addr_o  <= addr_i;
        act_wdata_o <= wdata_i;
      end
    end
  end

  // R1
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R1
  ack_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(cyc_i && stb_i));
endmodule

// File: rtl/uart_bus_frontend.sv
module uart_bus_frontend
  import uart_fe_pkg::*;
#(
  parameter int              LG         = 4,
  parameter logic [30:0]     INIT_SETUP = 31'd868
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cyc_i,
  input  logic        stb_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic        ack_o,
  output logic [31:0] rdata_o,
  output logic [30:0] setup_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        rx_brk_i,
  input  logic        rx_frame_err_i,
  input  logic        rx_par_err_i,
  output logic        rx_reset_o,
  output logic        cts_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_byte_o,
  input  logic        tx_busy_i,
  input  logic        tx_line_i,
  output logic        tx_break_o,
  input  logic        rts_i,
  output logic        rx_int_o,
  output logic        tx_int_o,
  output logic        rxfifo_int_o,
  output logic        txfifo_int_o
);
  localparam int DEPTH = 1 << LG;
  localparam int HALF  = DEPTH / 2;
  localparam int RXW   = 11;

  logic        act, act_we;
  logic [1:0]  act_addr;
  logic [31:0] act_wdata;

  fe_bus_stage u_stage (
    .clk_i, .rst_ni, .cyc_i, .stb_i, .we_i, .addr_i, .wdata_i,
    .act_o(act), .act_we_o(act_we), .act_addr_o(act_addr),
    .act_wdata_o(act_wdata), .ack_o
  );

  logic [30:0] setup_q;
  logic        rx_err_q, tx_err_q, brk_q;

  // receive side
  logic [RXW-1:0] rx_head;
  logic [LG:0]    rx_count;
  logic           rx_full, rx_empty, rx_clr, rx_rd, rx_push;

  assign rx_clr  = act && act_we && (act_addr == REG_RXDAT) && act_wdata[RX_ERR_B];
  assign rx_rd   = act && !act_we && (act_addr == REG_RXDAT);
  assign rx_push = rx_valid_i && !rx_full && !rx_clr;

  fe_fifo #(.W(RXW), .LG(LG)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(rx_clr), .push_i(rx_push), .pop_i(rx_rd),
    .data_i({rx_par_err_i, rx_frame_err_i, rx_brk_i, rx_byte_i}),
    .data_o(rx_head), .count_o(rx_count), .full_o(rx_full), .empty_o(rx_empty)
  );

  // transmit side
  logic [7:0]  tx_head;
  logic [LG:0] tx_count, tx_free;
  logic        tx_full, tx_empty, tx_wr, tx_clr, brk_set, brk_end;
  logic        tx_push_req, tx_pop;

  assign tx_wr       = act && act_we && (act_addr == REG_TXDAT);
  assign tx_clr      = tx_wr && act_wdata[TX_ERR_B];
  assign brk_set     = tx_wr && !act_wdata[TX_ERR_B] && act_wdata[TX_BRK_B];
  assign brk_end     = tx_wr && !act_wdata[TX_ERR_B] && !act_wdata[TX_BRK_B] && brk_q;
  assign tx_push_req = tx_wr && !act_wdata[TX_ERR_B] && !act_wdata[TX_BRK_B] && !brk_q;
  assign tx_valid_o  = !tx_empty && !brk_q && (setup_q[SETUP_NOFLOW] || rts_i);
  assign tx_pop      = tx_valid_o && !tx_busy_i;
  assign tx_byte_o   = tx_head;
  assign tx_free     = (LG+1)'(DEPTH) - tx_count;

  fe_fifo #(.W(8), .LG(LG)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_clr), .push_i(tx_push_req), .pop_i(tx_pop),
    .data_i(act_wdata[7:0]), .data_o(tx_head), .count_o(tx_count),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  // control state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q  <= INIT_SETUP;
      rx_err_q <= 1'b0;
      tx_err_q <= 1'b0;
      brk_q    <= 1'b0;
    end else begin
      if (act && act_we && (act_addr == REG_SETUP)) setup_q <= act_wdata[30:0];
      if (rx_clr)                     rx_err_q <= 1'b0;
      else if (rx_valid_i && rx_full) rx_err_q <= 1'b1;
      if (tx_clr)                      tx_err_q <= 1'b0;
      else if (tx_push_req && tx_full) tx_err_q <= 1'b1;
      if (brk_set)      brk_q <= 1'b1;
      else if (brk_end) brk_q <= 1'b0;
    end
  end

  // status words
  logic        rx_half, tx_free_half, tx_half;
  logic [15:0] rx_stat, tx_stat;
  logic [31:0] rd_mux;

  assign rx_half      = rx_count >= (LG+1)'(HALF);
  assign tx_free_half = tx_free  >= (LG+1)'(HALF);
  assign tx_half      = tx_count >= (LG+1)'(HALF);
  assign rx_stat = {4'(LG), FILL_W'(rx_count), rx_half, !rx_empty};
  assign tx_stat = {4'(LG), FILL_W'(tx_free), tx_free_half, !tx_full};

  always_comb begin
    rd_mux = '0;
    unique case (act_addr)
      REG_SETUP: rd_mux = {1'b0, setup_q};
      REG_FSTAT: rd_mux = {rx_stat, tx_stat};
      REG_RXDAT: begin
        rd_mux[RX_ERR_B]   = rx_err_q;
        rd_mux[RX_EMPTY_B] = rx_empty;
        if (!rx_empty) begin
          rd_mux[7:0]      = rx_head[7:0];
          rd_mux[RX_BRK_B] = rx_head[8];
          rd_mux[RX_FRM_B] = rx_head[9];
          rd_mux[RX_PAR_B] = rx_head[10];
        end
      end
      REG_TXDAT: begin
        rd_mux[TX_BUSY_B]  = !tx_empty || tx_busy_i;
        rd_mux[TX_BRK_B]   = brk_q;
        rd_mux[TX_LINE_B]  = tx_line_i;
        rd_mux[TX_ERR_B]   = tx_err_q;
        rd_mux[TX_NFULL_B] = !tx_full;
        rd_mux[TX_HALF_B]  = tx_half;
        rd_mux[TX_RTS_B]   = rts_i;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (act && !act_we)  rdata_o <= rd_mux;
  end

  assign setup_o      = setup_q;
  assign tx_break_o   = brk_q;
  assign rx_reset_o   = rx_clr;
  assign cts_o        = !rx_full;
  assign rx_int_o     = !rx_empty;
  assign tx_int_o     = !tx_full;
  assign rxfifo_int_o = rx_half;
  assign txfifo_int_o = tx_free_half;

  logic unused_bits;
  assign unused_bits = ^{act_wdata[31], act_wdata[10], act_wdata[8]};

  // R6
  rx_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !cts_o && !rx_clr) |=> rx_err_q);
  // R9
  brk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_break_o |-> !tx_valid_o);
  // R11
  tx_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_req && tx_full && !tx_clr) |=> tx_err_q);
  // R8
  tx_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !setup_o[SETUP_NOFLOW]) |-> rts_i);
endmodule

// File: tb/uart_bus_frontend_bench.sv
`timescale 1ns/1ps
module uart_bus_frontend_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cyc = 0, stb = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        ack_o;
  logic [31:0] rdata_o;
  logic [30:0] setup_o;
  logic        rx_valid = 0, rx_brk = 0, rx_frm = 0, rx_par = 0;
  logic [7:0]  rx_byte = 0;
  logic        rx_reset_o, cts_o, tx_valid_o, tx_break_o;
  logic [7:0]  tx_byte_o;
  logic        tx_busy = 0, tx_line = 1, rts = 0;
  logic        rx_int_o, tx_int_o, rxfifo_int_o, txfifo_int_o;

  uart_bus_frontend u_uart_bus_frontend (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .ack_o, .rdata_o, .setup_o,
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .rx_brk_i(rx_brk),
    .rx_frame_err_i(rx_frm), .rx_par_err_i(rx_par), .rx_reset_o, .cts_o,
    .tx_valid_o, .tx_byte_o, .tx_busy_i(tx_busy), .tx_line_i(tx_line),
    .tx_break_o, .rts_i(rts), .rx_int_o, .tx_int_o, .rxfifo_int_o, .txfifo_int_o
  );

  int n_cmp = 0, n_bad = 0, tx_got = 0, busy_cnt = 0;
  logic [31:0] exp_q[$], msk_q[$];
  string       tag_q[$];
  logic [7:0]  exp_tx[$];
  logic        rxrst_seen = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: queue expectation, run one handshake
  task automatic bus(input logic w, input logic [1:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input logic [31:0] msk, input string tag);
    exp_q.push_back(exp); msk_q.push_back(w ? 32'h0 : msk); tag_q.push_back(tag);
    @(negedge clk); cyc = 1; stb = 1; we = w; addr = a; wdata = d;
    do @(negedge clk); while (!ack_o);
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus(1'b1, a, d, 32'h0, 32'h0, "wr");
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input logic [31:0] msk,
                    input string tag);
    bus(1'b0, a, 32'h0, exp, msk, tag);
  endtask

  task automatic rx_put(input logic [7:0] b, input logic brk, input logic frm, input logic par);
    @(negedge clk); rx_valid = 1; rx_byte = b; rx_brk = brk; rx_frm = frm; rx_par = par;
    @(negedge clk); rx_valid = 0; rx_brk = 0; rx_frm = 0; rx_par = 0;
  endtask

  // bus monitor
  always @(negedge clk) begin
    if (rst_n && ack_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1: unexpected ack got %h expected none", rdata_o);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic logic [31:0] m = msk_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (m != 0) chk(t, rdata_o & m, e & m);
      end
    end
  end

  // transmitter engine model and its scoreboard
  always @(posedge clk) begin
    if (rx_reset_o) rxrst_seen <= 1'b1;
    if (tx_valid_o && !tx_busy) begin
      tx_got++;
      tx_busy  <= 1'b1;
      busy_cnt <= 4;
      n_cmp++;
      if (exp_tx.size() == 0) begin
        n_bad++;
        $display("FAIL R8: byte %h sent, expected none", tx_byte_o);
      end else begin
        automatic logic [7:0] e = exp_tx.pop_front();
        if (tx_byte_o !== e) begin
          n_bad++;
          $display("FAIL R8: byte got %h expected %h", tx_byte_o, e);
        end
      end
    end else if (tx_busy) begin
      if (busy_cnt == 1) tx_busy <= 1'b0;
      busy_cnt <= busy_cnt - 1;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R2 setup_o reset", {1'b0, setup_o}, 32'd868);
    chk("R12 reset irqs", {28'h0, rx_int_o, tx_int_o, rxfifo_int_o, txfifo_int_o}, 32'h5);
    chk("R6 cts reset", {31'h0, cts_o}, 32'h1);
    rd(2'd0, 32'd868, 32'hFFFF_FFFF, "R2 setup reset read");
    // R1 R2 setup round trip
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R2 setup readback");
    chk("R2 setup_o", {1'b0, setup_o}, 32'h7FFF_FFFF);
    wr(2'd0, 32'd868);
    // R3 status, write ignored
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h4000_4043, 32'hFFFF_FFFF, "R3 status idle");
    // R4 R5 receive path
    rx_put(8'hA5, 0, 1, 0);
    rx_put(8'h3C, 0, 0, 0);
    rx_put(8'h7E, 1, 0, 1);
    chk("R12 rx_int", {31'h0, rx_int_o}, 32'h1);
    rd(2'd2, 32'h0000_04A5, 32'h1FFF, "R4 rx frame flag");
    rd(2'd2, 32'h0000_003C, 32'h1FFF, "R4 rx clean");
    rd(2'd2, 32'h0000_0A7E, 32'h1FFF, "R4 rx brk par");
    rd(2'd2, 32'h0000_0100, 32'h1100, "R5 rx empty");
    chk("R5 rx_int empty", {31'h0, rx_int_o}, 32'h0);
    // R6 overflow
    for (int i = 0; i < 17; i++) rx_put(8'h10 + 8'(i), 0, 0, 0);
    chk("R6 cts full", {31'h0, cts_o}, 32'h0);
    chk("R12 rx irqs full", {30'h0, rx_int_o, rxfifo_int_o}, 32'h3);
    rd(2'd1, 32'h4043_4043, 32'hFFFF_FFFF, "R3 status rx full");
    rd(2'd2, 32'h0000_1010, 32'h1FFF, "R6 rx overflow flag");
    // R7 receive clear
    wr(2'd2, 32'h0000_1000);
    chk("R7 rx_reset pulse", {31'h0, rxrst_seen}, 32'h1);
    rd(2'd2, 32'h0000_0100, 32'h1100, "R7 rx cleared");
    chk("R7 cts after clear", {31'h0, cts_o}, 32'h1);
    // R8 flow control hold then release
    rts = 0;
    wr(2'd3, 32'h11); exp_tx.push_back(8'h11);
    wr(2'd3, 32'h22); exp_tx.push_back(8'h22);
    repeat (20) @(negedge clk);
    chk("R8 held by rts", tx_got, 0);
    rd(2'd3, 32'h0000_1500, 32'h7F00, "R10 tx busy queued");
    rts = 1;
    repeat (40) @(negedge clk);
    chk("R8 sent count", tx_got, 2);
    rd(2'd3, 32'h0000_5400, 32'h7F00, "R10 tx idle");
    // R9 break
    wr(2'd3, 32'h0000_0200);
    chk("R9 break on", {31'h0, tx_break_o}, 32'h1);
    rd(2'd3, 32'h0000_5600, 32'h7F00, "R10 tx in break");
    wr(2'd3, 32'h55);
    repeat (20) @(negedge clk);
    chk("R9 break off", {31'h0, tx_break_o}, 32'h0);
    chk("R9 break end sends nothing", tx_got, 2);
    wr(2'd3, 32'h66); exp_tx.push_back(8'h66);
    repeat (20) @(negedge clk);
    chk("R8 after break", tx_got, 3);
    tx_line = 0;
    rd(2'd3, 32'h0000_5000, 32'h7F00, "R10 line low");
    tx_line = 1;
    // R11 transmit overflow and clear
    rts = 0;
    for (int i = 0; i < 17; i++) wr(2'd3, 32'h80 + i);
    chk("R12 tx irqs full", {30'h0, tx_int_o, txfifo_int_o}, 32'h0);
    rd(2'd3, 32'h0000_2D00, 32'h7F00, "R11 tx overflow");
    rd(2'd1, 32'h4000_4000, 32'hFFFF_FFFF, "R3 status tx full");
    wr(2'd3, 32'h0000_0800);
    rd(2'd3, 32'h0000_1400, 32'h7F00, "R11 tx cleared");
    rts = 1;
    repeat (20) @(negedge clk);
    chk("R11 nothing after clear", tx_got, 3);
    chk("R12 tx irqs empty", {30'h0, tx_int_o, txfifo_int_o}, 32'h3);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule